// File: doc/BRIEF.md
# Nested Priority Interrupt Resolver

This block arbitrates among interrupt requests spread over a 32-level priority space, where level 0 is the most urgent. Level 0 belongs to the non-maskable source. Levels 1 to 15 carry the cascaded legacy IRQ lines, in a fixed order where every secondary-controller line ranks above IRQ3 to IRQ7. Levels 16 to 31 are auxiliary sources of lowest rank. Each level holds one latched request bit. The block filters the pending bits through the mask and in-service state, compares the best candidate with the level that is executing now, and offers the winner on a valid/ready grant port together with an interrupt vector.

An accepted legacy grant puts its level in service and pushes the previously executing level onto a nesting stack. Any end-of-interrupt pulse retires the level that is executing now and pops the one below it, whatever level a specific EOI would name. The non-maskable and auxiliary levels leave service at the moment they are accepted. A periodic watchdog tick forces through any request that stays eligible but ungranted across two ticks in a row.

The grant port follows valid/ready rules. The offer may be withdrawn or replaced by a more urgent level while `grant_ready` is low. Nothing changes state until a cycle with both `grant_valid` and `grant_ready` high. Back-pressure never drops a request: an unaccepted request stays pending.

Top module: `irq_nest_resolver`

## Requirements
- R1: After reset no request is pending, `cur_level` reads 32 (idle), `grant_valid` is low and `casc_active` is low.
- R2: A pulse on `legacy_req[k]` sets the pending bit of level 1 for k=0, level 2 for k=1, level k-5 for k=8..15, and level k+8 for k=3..7. Bit 2 counts as IRQ9 (level 4). For levels 1 to 15, `grant_legacy` is 1 and `grant_vector` is {base, k[2:0]}, with base taken from `pri_vbase` for k<8 and from `sec_vbase` otherwise. For all other levels both are 0.
- R3: The candidate is the lowest-numbered level that is pending, unmasked and not in service. Level 0 has no mask. Level 16+a is masked by `aux_mask[a]`, primary IRQ k by `pri_mask[k]`, and secondary IRQ k by `sec_mask[k-8]`.
- R4: While `pri_mask[2]` is 1, no secondary IRQ (levels 3 to 10) can be offered.
- R5: An unforced candidate is offered only if its level is below `cur_level`, except when `special_mask` is 1, which bypasses the comparison.
- R6: Acceptance (valid and ready high together) clears that level's pending bit. For levels 1 to 15 it also marks the level in service, pushes the old `cur_level`, and makes `cur_level` equal the granted level on the next cycle.
- R7: Accepting level 0 or levels 16 to 31 clears the pending bit and leaves `cur_level` unchanged.
- R8: `casc_active` is 1 exactly while some level from 3 to 10 is in service.
- R9: An `eoi` pulse while not idle clears the in-service state of `cur_level` and restores the level pushed before it. When idle, it has no effect. During an `eoi` cycle, `grant_valid` is low.
- R10: A level queues at most one request. Repeated pulses while the level is pending yield a single grant. A pulse that arrives in the cycle its level is accepted leaves the level pending again.
- R11: Each `wd_tick` records which levels are eligible and ungranted. If such a level is still eligible at the next tick, it becomes forced. The lowest forced eligible level is offered regardless of `cur_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_req | input | 16 | Legacy IRQ request pulses, bit k is IRQk |
| nmi_req | input | 1 | Non-maskable request pulse (level 0) |
| aux_req | input | 16 | Auxiliary request pulses, bit a is level 16+a |
| pri_mask | input | 8 | Primary IRQ mask, bit 2 also masks all secondary IRQs |
| sec_mask | input | 8 | Secondary IRQ mask (IRQ8..IRQ15) |
| aux_mask | input | 16 | Auxiliary level mask |
| special_mask | input | 1 | Bypass the rank comparison with the executing level |
| pri_vbase | input | 5 | Upper vector bits for IRQ0..IRQ7 |
| sec_vbase | input | 5 | Upper vector bits for IRQ8..IRQ15 |
| eoi | input | 1 | End-of-interrupt pulse |
| wd_tick | input | 1 | Watchdog tick pulse |
| grant_ready | input | 1 | Consumer accepts the offered grant |
| grant_valid | output | 1 | A grant is offered |
| grant_level | output | 5 | Offered level |
| grant_vector | output | 8 | Vector of the offered legacy level, else 0 |
| grant_legacy | output | 1 | Offered level is a legacy IRQ |
| cur_level | output | 6 | Executing level, 32 when idle |
| casc_active | output | 1 | A secondary IRQ is in service |

## Verification
A stale in-service bit or a corrupted stack entry shows up on `cur_level` on the first EOI after the fault. It also shows up on `grant_valid`: an eligible level stays blocked, or a level that should stay blocked gets offered. A lost or doubled pending bit changes the number of grants seen at the port one cycle after the request. A bad watchdog flag appears as an offer on the cycle after the second tick. The reference model is compared with every output on every clock, so a divergence is reported on the cycle it reaches the ports.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NLVL    = 32;
  localparam int LVL_W   = $clog2(NLVL);
  localparam int CUR_W   = LVL_W + 1;
  localparam int LEG_N   = 16;
  localparam int AUX_N   = 16;
  localparam int AUX_LO  = NLVL - AUX_N;
  localparam int SEC_LO  = 3;
  localparam int SEC_HI  = 10;
  localparam int VEC_W   = 8;
  localparam int VBASE_W = VEC_W - 3;
  localparam logic [CUR_W-1:0] IDLE = CUR_W'(NLVL);

  typedef logic [NLVL-1:0] lvl_vec_t;

  function automatic logic [LVL_W-1:0] lvl_of_irq(input int k);
    if (k == 0)      return LVL_W'(1);
    else if (k == 1) return LVL_W'(2);
    else if (k == 2) return LVL_W'(4);
    else if (k < 8)  return LVL_W'(k + 8);
    else             return LVL_W'(k - 5);
  endfunction

  function automatic logic [3:0] irq_of_lvl(input logic [LVL_W-1:0] l);
    if (l == LVL_W'(1))       return 4'd0;
    else if (l == LVL_W'(2))  return 4'd1;
    else if (l <= LVL_W'(SEC_HI)) return 4'(l + 5);
    else                      return 4'(l - 8);
  endfunction

  function automatic logic is_auto(input logic [LVL_W-1:0] l);
    return (l == '0) || (l >= LVL_W'(AUX_LO));
  endfunction

  function automatic logic is_sec(input logic [LVL_W-1:0] l);
    return (l >= LVL_W'(SEC_LO)) && (l <= LVL_W'(SEC_HI));
  endfunction

  function automatic logic [LVL_W:0] first_set(input lvl_vec_t v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, LVL_W'(i)};
    return r;
  endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_nest_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEG_N-1:0] legacy_req,
  input  logic             nmi_req,
  input  logic [AUX_N-1:0] aux_req,
  input  logic             clr_en,
  input  logic [LVL_W-1:0] clr_lvl,
  output lvl_vec_t         pend
);
  lvl_vec_t req_vec, clr_vec, pend_q;

  always_comb begin
    req_vec    = '0;
    req_vec[0] = nmi_req;
    for (int k = 0; k < LEG_N; k++)
      req_vec[lvl_of_irq(k)] = req_vec[lvl_of_irq(k)] | legacy_req[k];
    for (int a = 0; a < AUX_N; a++)
      req_vec[AUX_LO + a] = aux_req[a];
  end

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec[clr_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | req_vec;
  end

  assign pend = pend_q;

  assert_clear_on_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !req_vec[clr_lvl]) |=> !pend_q[$past(clr_lvl)]);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_nest_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  lvl_vec_t           pend,
  input  lvl_vec_t           isr,
  input  logic [7:0]         pri_mask,
  input  logic [7:0]         sec_mask,
  input  logic [AUX_N-1:0]   aux_mask,
  input  logic               special_mask,
  input  logic [CUR_W-1:0]   cur_level,
  input  logic               eoi,
  input  logic               wd_tick,
  input  logic               acc,
  output logic               cand_valid,
  output logic [LVL_W-1:0]   cand_lvl,
  output logic               cand_forced
);
  lvl_vec_t lmask, elig, gvec, seen_q, force_q;
  logic [LVL_W:0] f_hit, e_hit;
  logic [3:0] irq;
  logic ok;

  always_comb begin
    lmask = '0;
    for (int l = 1; l < NLVL; l++) begin
      irq = irq_of_lvl(LVL_W'(l));
      if (l >= AUX_LO)  lmask[l] = aux_mask[l - AUX_LO];
      else if (irq[3])  lmask[l] = sec_mask[irq[2:0]] | pri_mask[2];
      else              lmask[l] = pri_mask[irq[2:0]];
    end
  end

  assign elig  = pend & ~(lmask | isr);
  assign f_hit = first_set(elig & force_q);
  assign e_hit = first_set(elig);

  always_comb begin
    if (f_hit[LVL_W]) begin
      cand_lvl    = f_hit[LVL_W-1:0];
      cand_forced = 1'b1;
      ok          = 1'b1;
    end else begin
      cand_lvl    = e_hit[LVL_W-1:0];
      cand_forced = 1'b0;
      ok          = e_hit[LVL_W] && (special_mask || ({1'b0, cand_lvl} < cur_level));
    end
    cand_valid = ok && !eoi;
  end

  always_comb begin
    gvec = '0;
    if (acc) gvec[cand_lvl] = 1'b1;
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_wd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_q[l]  <= 1'b0;
        force_q[l] <= 1'b0;
      end else begin
        seen_q[l]  <= wd_tick ? (elig[l] && !gvec[l]) : (seen_q[l] && !gvec[l]);
        force_q[l] <= (force_q[l] || (wd_tick && seen_q[l] && elig[l])) && elig[l] && !gvec[l];
      end
    end
  end

  assert_rank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !special_mask && !cand_forced) |-> ({1'b0, cand_lvl} < cur_level));
  assert_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (pend[cand_lvl] && !isr[cand_lvl] && !lmask[cand_lvl]));
  assert_cascade_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !(pri_mask[2] && is_sec(cand_lvl)));
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_nest_pkg::*;
#(
  parameter int DEPTH = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [LVL_W-1:0] acc_lvl,
  input  logic             eoi,
  output lvl_vec_t         isr,
  output logic [CUR_W-1:0] cur_level,
  output logic             casc_active
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int SP_W  = PTR_W + 1;
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

  logic [CUR_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d, sp_m1;
  logic [CUR_W-1:0] cur_q, cur_d;
  lvl_vec_t         isr_q, isr_d;
  logic             casc_q, push, pop;

  assign push  = acc && !is_auto(acc_lvl) && (sp_q < SP_FULL);
  assign pop   = eoi && (cur_q != IDLE);
  assign sp_m1 = sp_q - SP_W'(1);

  always_comb begin
    isr_d = isr_q;
    cur_d = cur_q;
    sp_d  = sp_q;
    if (pop) begin
      isr_d[cur_q[LVL_W-1:0]] = 1'b0;
      cur_d = stk[sp_m1[PTR_W-1:0]];
      sp_d  = sp_m1;
    end else if (push) begin
      isr_d[acc_lvl] = 1'b1;
      cur_d = {1'b0, acc_lvl};
      sp_d  = sp_q + SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q  <= '0;
      cur_q  <= IDLE;
      sp_q   <= '0;
      casc_q <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      cur_q  <= cur_d;
      sp_q   <= sp_d;
      casc_q <= |isr_d[SEC_HI:SEC_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pop) stk[sp_q[PTR_W-1:0]] <= cur_q;
  end

  assign isr         = isr_q;
  assign cur_level   = cur_q;
  assign casc_active = casc_q;

  assert_push_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_auto(acc_lvl) && !eoi) |=> (cur_q == {1'b0, $past(acc_lvl)}));
  assert_auto_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_auto(acc_lvl) && !eoi) |=> $stable(cur_q));
  assert_idle_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && cur_q == IDLE && !acc) |=> (cur_q == IDLE));
  assert_cur_in_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != IDLE) |-> isr_q[cur_q[LVL_W-1:0]]);
  assert_secondary_cur_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q >= CUR_W'(SEC_LO) && cur_q <= CUR_W'(SEC_HI)) |-> casc_q);
endmodule

// File: rtl/irq_nest_resolver.sv
module irq_nest_resolver
  import irq_nest_pkg::*;
#(
  parameter int STACK_DEPTH = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEG_N-1:0]   legacy_req,
  input  logic               nmi_req,
  input  logic [AUX_N-1:0]   aux_req,
  input  logic [7:0]         pri_mask,
  input  logic [7:0]         sec_mask,
  input  logic [AUX_N-1:0]   aux_mask,
  input  logic               special_mask,
  input  logic [VBASE_W-1:0] pri_vbase,
  input  logic [VBASE_W-1:0] sec_vbase,
  input  logic               eoi,
  input  logic               wd_tick,
  input  logic               grant_ready,
  output logic               grant_valid,
  output logic [LVL_W-1:0]   grant_level,
  output logic [VEC_W-1:0]   grant_vector,
  output logic               grant_legacy,
  output logic [CUR_W-1:0]   cur_level,
  output logic               casc_active
);
  lvl_vec_t         pend, isr;
  logic             cand_valid, cand_forced, acc;
  logic [LVL_W-1:0] cand_lvl;
  logic [3:0]       irq;

  assign acc = cand_valid && grant_ready;

  irq_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .legacy_req(legacy_req), .nmi_req(nmi_req),
    .aux_req(aux_req), .clr_en(acc), .clr_lvl(cand_lvl), .pend(pend)
  );

  irq_prio_pick u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend), .isr(isr), .pri_mask(pri_mask),
    .sec_mask(sec_mask), .aux_mask(aux_mask), .special_mask(special_mask),
    .cur_level(cur_level), .eoi(eoi), .wd_tick(wd_tick), .acc(acc),
    .cand_valid(cand_valid), .cand_lvl(cand_lvl), .cand_forced(cand_forced)
  );

  irq_nest_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_lvl(cand_lvl), .eoi(eoi),
    .isr(isr), .cur_level(cur_level), .casc_active(casc_active)
  );

  always_comb begin
    irq          = irq_of_lvl(cand_lvl);
    grant_legacy = !is_auto(cand_lvl);
    if (grant_legacy)
      grant_vector = {(irq[3] ? sec_vbase : pri_vbase), irq[2:0]};
    else
      grant_vector = '0;
  end

  assign grant_valid = cand_valid;
  assign grant_level = cand_lvl;

  assert_forced_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_forced && !eoi) |-> grant_valid);
endmodule

// File: tb/sim_irq_nest_resolver.sv
module sim_irq_nest_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] legacy_req = '0, aux_req = '0, aux_mask = '0;
  logic nmi_req = 1'b0, special_mask = 1'b0, eoi = 1'b0, wd_tick = 1'b0, grant_ready = 1'b1;
  logic [7:0] pri_mask = '0, sec_mask = '0;
  logic [4:0] pri_vbase = 5'h01, sec_vbase = 5'h0E;
  logic grant_valid, grant_legacy, casc_active;
  logic [4:0] grant_level;
  logic [7:0] grant_vector;
  logic [5:0] cur_level;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_nest_resolver u0 (
    .clk(clk), .rst_n(rst_n), .legacy_req(legacy_req), .nmi_req(nmi_req),
    .aux_req(aux_req), .pri_mask(pri_mask), .sec_mask(sec_mask), .aux_mask(aux_mask),
    .special_mask(special_mask), .pri_vbase(pri_vbase), .sec_vbase(sec_vbase),
    .eoi(eoi), .wd_tick(wd_tick), .grant_ready(grant_ready), .grant_valid(grant_valid),
    .grant_level(grant_level), .grant_vector(grant_vector), .grant_legacy(grant_legacy),
    .cur_level(cur_level), .casc_active(casc_active)
  );

  // behavioural reference state
  int m_pend[32], m_isr[32], m_seen[32], m_frc[32], m_elig[32];
  int m_cur;
  int m_stk[$];
  int m_valid, m_win;

  function automatic int irq_of(int l);
    if (l == 1) return 0;
    if (l == 2) return 1;
    if (l <= 10) return l + 5;
    return l - 8;
  endfunction

  function automatic int lvl_of(int k);
    if (k == 0) return 1;
    if (k == 1) return 2;
    if (k == 2) return 4;
    if (k < 8) return k + 8;
    return k - 5;
  endfunction

  function automatic bit masked(int l);
    int k;
    if (l == 0) return 0;
    if (l >= 16) return aux_mask[l-16];
    k = irq_of(l);
    if (k < 8) return pri_mask[k];
    return sec_mask[k-8] | pri_mask[2];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_eval();
    int fw, ew;
    fw = -1; ew = -1;
    for (int l = 31; l >= 0; l--) begin
      m_elig[l] = (m_pend[l] != 0 && !masked(l) && m_isr[l] == 0) ? 1 : 0;
      if (m_elig[l] != 0 && m_frc[l] != 0) fw = l;
      if (m_elig[l] != 0) ew = l;
    end
    if (fw >= 0) begin m_win = fw; m_valid = 1; end
    else if (ew >= 0) begin m_win = ew; m_valid = (special_mask || ew < m_cur) ? 1 : 0; end
    else begin m_win = 0; m_valid = 0; end
    if (eoi) m_valid = 0;
  endtask

  task automatic m_compare();
    int evec, eleg, ecasc, k;
    m_eval();
    chk(grant_valid == m_valid, "R5 grant_valid", grant_valid, m_valid);
    if (m_valid != 0) begin
      chk(grant_level == m_win, "R3 grant_level", grant_level, m_win);
      eleg = (m_win >= 1 && m_win <= 15) ? 1 : 0;
      evec = 0;
      if (eleg != 0) begin
        k = irq_of(m_win);
        evec = (k < 8 ? int'(pri_vbase) : int'(sec_vbase)) * 8 + (k % 8);
      end
      chk(grant_legacy == eleg, "R2 grant_legacy", grant_legacy, eleg);
      chk(grant_vector == evec, "R2 grant_vector", grant_vector, evec);
    end
    chk(cur_level == m_cur, "R9 cur_level", cur_level, m_cur);
    ecasc = 0;
    for (int l = 3; l <= 10; l++) if (m_isr[l] != 0) ecasc = 1;
    chk(casc_active == ecasc, "R8 casc_active", casc_active, ecasc);
  endtask

  task automatic m_update();
    int acc, req[32], g;
    acc = (m_valid != 0 && grant_ready) ? 1 : 0;
    for (int l = 0; l < 32; l++) req[l] = 0;
    req[0] = nmi_req;
    for (int k = 0; k < 16; k++) if (legacy_req[k]) req[lvl_of(k)] = 1;
    for (int a = 0; a < 16; a++) if (aux_req[a]) req[16+a] = 1;
    for (int l = 0; l < 32; l++) begin
      g = (acc != 0 && m_win == l) ? 1 : 0;
      m_frc[l]  = ((m_frc[l] != 0 || (wd_tick && m_seen[l] != 0 && m_elig[l] != 0))
                   && m_elig[l] != 0 && g == 0) ? 1 : 0;
      m_seen[l] = wd_tick ? ((m_elig[l] != 0 && g == 0) ? 1 : 0)
                          : ((m_seen[l] != 0 && g == 0) ? 1 : 0);
      m_pend[l] = ((m_pend[l] != 0 && g == 0) || req[l] != 0) ? 1 : 0;
    end
    if (eoi && m_cur != 32) begin
      m_isr[m_cur] = 0;
      m_cur = m_stk.pop_back();
    end else if (acc != 0 && m_win >= 1 && m_win <= 15) begin
      m_isr[m_win] = 1;
      m_stk.push_back(m_cur);
      m_cur = m_win;
    end
  endtask

  task automatic tick();
    #1;
    m_compare();
    m_update();
    @(posedge clk);
    #1;
    legacy_req = '0; aux_req = '0; nmi_req = 1'b0; eoi = 1'b0; wd_tick = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 32; l++) begin
      m_pend[l] = 0; m_isr[l] = 0; m_seen[l] = 0; m_frc[l] = 0; m_elig[l] = 0;
    end
    m_cur = 32;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(grant_valid == 1'b0, "R1 valid after reset", grant_valid, 0);
    chk(cur_level == 6'd32, "R1 idle level", cur_level, 32);
    chk(casc_active == 1'b0, "R1 cascade flag", casc_active, 0);

    // nesting: IRQ4 then IRQ0, IRQ5 blocked
    legacy_req[4] = 1'b1; tick();
    chk(grant_valid && grant_level == 5'd12, "R6 IRQ4 offered", grant_level, 12);
    chk(grant_vector == 8'h0C, "R2 IRQ4 vector", grant_vector, 8'h0C);
    tick();
    chk(cur_level == 6'd12, "R6 IRQ4 in service", cur_level, 12);
    legacy_req[0] = 1'b1; legacy_req[5] = 1'b1; tick();
    chk(grant_level == 5'd1, "R3 IRQ0 wins", grant_level, 1);
    tick();
    chk(cur_level == 6'd1, "R6 nested push", cur_level, 1);
    chk(grant_valid == 1'b0, "R5 IRQ5 blocked", grant_valid, 0);
    eoi = 1'b1; tick();
    chk(cur_level == 6'd12, "R9 restore level", cur_level, 12);
    eoi = 1'b1; tick();
    chk(cur_level == 6'd32 && grant_level == 5'd13, "R9 unwind to idle", cur_level, 32);
    tick();
    eoi = 1'b1; tick();
    eoi = 1'b1; tick();
    chk(cur_level == 6'd32, "R9 eoi when idle", cur_level, 32);

    // IRQ2 alias, cascade mask, cascade flag
    grant_ready = 1'b0;
    legacy_req[2] = 1'b1; tick();
    chk(grant_level == 5'd4 && grant_vector == 8'h71, "R2 IRQ2 as IRQ9", grant_vector, 8'h71);
    pri_mask = 8'h04; #1;
    chk(grant_valid == 1'b0, "R4 cascade masked", grant_valid, 0);
    tick();
    pri_mask = 8'h00; grant_ready = 1'b1; tick();
    chk(casc_active == 1'b1 && cur_level == 6'd4, "R8 cascade set", casc_active, 1);
    eoi = 1'b1; tick();
    chk(casc_active == 1'b0, "R8 cascade cleared", casc_active, 0);

    // auto-EOI levels
    aux_req[3] = 1'b1; tick();
    chk(grant_level == 5'd19 && !grant_legacy && grant_vector == 8'h00, "R7 aux offer", grant_level, 19);
    tick();
    chk(cur_level == 6'd32 && !grant_valid, "R7 aux auto done", cur_level, 32);
    pri_mask = 8'hFF; sec_mask = 8'hFF; aux_mask = 16'hFFFF;
    nmi_req = 1'b1; tick();
    chk(grant_valid && grant_level == 5'd0, "R3 nmi unmaskable", grant_level, 0);
    tick();
    chk(cur_level == 6'd32, "R7 nmi auto done", cur_level, 32);
    pri_mask = '0; sec_mask = '0; aux_mask = '0;

    // depth-one queue
    grant_ready = 1'b0;
    legacy_req[6] = 1'b1; tick();
    legacy_req[6] = 1'b1; tick();
    grant_ready = 1'b1; tick();
    chk(cur_level == 6'd14 && !grant_valid, "R10 single grant", grant_valid, 0);
    eoi = 1'b1; tick();

    // special mask bypass
    legacy_req[3] = 1'b1; tick(); tick();
    legacy_req[5] = 1'b1; tick();
    chk(grant_valid == 1'b0, "R5 lower level blocked", grant_valid, 0);
    special_mask = 1'b1; #1;
    chk(grant_valid && grant_level == 5'd13, "R5 special mask bypass", grant_level, 13);
    tick();
    special_mask = 1'b0;
    eoi = 1'b1; tick();
    chk(cur_level == 6'd11, "R9 special mask unwind", cur_level, 11);
    eoi = 1'b1; tick();

    // watchdog forcing
    legacy_req[3] = 1'b1; tick(); tick();
    grant_ready = 1'b0;
    legacy_req[4] = 1'b1; tick();
    wd_tick = 1'b1; tick();
    chk(grant_valid == 1'b0, "R11 one tick not enough", grant_valid, 0);
    wd_tick = 1'b1; tick();
    chk(grant_valid && grant_level == 5'd12, "R11 forced offer", grant_level, 12);
    grant_ready = 1'b1; tick();
    chk(cur_level == 6'd12, "R11 forced grant taken", cur_level, 12);
    eoi = 1'b1; tick();
    eoi = 1'b1; tick();

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      legacy_req  = 16'($urandom & $urandom & $urandom & $urandom);
      aux_req     = 16'($urandom & $urandom & $urandom & $urandom);
      nmi_req     = ($urandom % 40) == 0;
      eoi         = ($urandom % 5) == 0;
      wd_tick     = ($urandom % 7) == 0;
      grant_ready = ($urandom % 4) != 0;
      if (c % 50 == 0) begin
        pri_mask = 8'($urandom & $urandom);
        sec_mask = 8'($urandom & $urandom);
        aux_mask = 16'($urandom & $urandom);
      end
      if (c % 200 == 0) special_mask = ($urandom % 3) == 0;
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule